// File: doc/BRIEF.md
# Banked Data-Memory Address Generator

This block turns the 8-bit file offset carried by a data-memory instruction into a 12-bit address into a 4 KB data space. It holds a 4-bit bank register that is loaded from a literal. When an instruction asks for banked addressing, the bank register is placed above the offset. When it asks for the shared window, the bank register is ignored. The lower half of the offset range then lands at the bottom of memory, and the upper half lands in the top 128 bytes, where the peripheral registers live.

Memory-to-memory copies carry their own full 12-bit addresses. A direct-mode select passes such an address straight to the output.

The address path is purely combinational from the pins and the bank register. No data is streamed through the block, so there is no valid/ready handshake and no back-pressure: every input is sampled level-wise, and only the bank register changes, on a clock edge.

Top module: `dmem_addr_gen`

## Requirements
- R1: After reset the bank register is 0, so a banked access with offset 0x70 yields address 0x070.
- R2: With `banked`=1 and `direct_sel`=0, the address is {bank, file_ofs}; for example, bank 1 with offset 0x70 gives 0x170.
- R3: With `banked`=0 and `direct_sel`=0, an offset 0x00–0x7F gives the address 0x000–0x07F whatever the bank register holds.
- R4: With `banked`=0 and `direct_sel`=0, an offset 0x80–0xFF gives the address 0xF80–0xFFF whatever the bank register holds.
- R5: A pulse on `bank_ld` loads bits [3:0] of `bank_lit` into the bank register. Bits [7:4] of the literal are discarded.
- R6: A load takes effect at the next rising clock edge. An access in the same cycle as the load still uses the old bank.
- R7: With `direct_sel`=1 the address equals `direct_addr`, regardless of `banked`, `file_ofs` and the bank register.
- R8: While `bank_ld` is 0 the bank register holds its value, including during direct-mode and shared-window accesses.
- R9: A bank load issued during a direct-mode access still updates the bank register, and banked accesses that follow use the new bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the bank register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears the bank register |
| file_ofs | input | 8 | File offset field from the instruction |
| banked | input | 1 | 1 = use the bank register, 0 = shared window |
| bank_ld | input | 1 | Load strobe for the bank register |
| bank_lit | input | 8 | Literal for a bank load; only bits [3:0] are kept |
| direct_sel | input | 1 | 1 = output the full direct address |
| direct_addr | input | 12 | Full address supplied by a memory-to-memory move |
| dmem_addr | output | 12 | Resulting data-memory address |

## Verification
A bank load and an address lookup can fall in the same cycle. The bench provokes this by raising `bank_ld` while it presents a banked access. It expects that access to show the old bank, and the following access to show the new one. A bank load can also coincide with a direct-mode copy. The bench presents both together and expects the direct address to pass through unchanged. It then checks that the next banked access carries the freshly loaded bank.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
  localparam int ADDR_W = 12;
  localparam int OFS_W  = 8;
  localparam int BANK_W = ADDR_W - OFS_W;
  localparam int LIT_W  = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [OFS_W-1:0]  ofs_t;
  typedef logic [BANK_W-1:0] bank_t;

  typedef enum logic [1:0] {
    SRC_BANKED = 2'd0,
    SRC_SHARED = 2'd1,
    SRC_DIRECT = 2'd2
  } addr_src_e;
endpackage

// File: rtl/dmag_bank_reg.sv
module dmag_bank_reg
  import dmag_pkg::*;
#(
  parameter int BW = BANK_W,
  parameter int LW = LIT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [LW-1:0] lit,
  output logic [BW-1:0] bank_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bank_q <= '0;
    else if (ld) bank_q <= lit[BW-1:0];
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(bank_q));
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> bank_q == $past(lit[BW-1:0]));
endmodule

// File: rtl/dmag_shared_map.sv
module dmag_shared_map
  import dmag_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OFS_W
) (
  input  logic [OW-1:0] ofs,
  output logic [AW-1:0] addr
);
  localparam int HW = AW - OW;
  // Upper half of the offset range folds onto the top of memory.
  always_comb begin
    addr = {{HW{ofs[OW-1]}}, ofs};
  end
endmodule

// File: rtl/dmem_addr_gen.sv
module dmem_addr_gen
  import dmag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFS_W-1:0]  file_ofs,
  input  logic              banked,
  input  logic              bank_ld,
  input  logic [LIT_W-1:0]  bank_lit,
  input  logic              direct_sel,
  input  logic [ADDR_W-1:0] direct_addr,
  output logic [ADDR_W-1:0] dmem_addr
);
  bank_t     bank_q;
  addr_t     shared_addr;
  addr_src_e src;

  dmag_bank_reg #(.BW(BANK_W), .LW(LIT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .ld(bank_ld), .lit(bank_lit), .bank_q(bank_q)
  );

  dmag_shared_map #(.AW(ADDR_W), .OW(OFS_W)) u_map (
    .ofs(file_ofs), .addr(shared_addr)
  );

  always_comb begin
    if (direct_sel)  src = SRC_DIRECT;
    else if (banked) src = SRC_BANKED;
    else             src = SRC_SHARED;
  end

  always_comb begin
    unique case (src)
      SRC_DIRECT: dmem_addr = direct_addr;
      SRC_BANKED: dmem_addr = {bank_q, file_ofs};
      default:    dmem_addr = shared_addr;
    endcase
  end

  a_r2_banked: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct_sel && banked) |-> dmem_addr == {bank_q, file_ofs});
  a_r3_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct_sel && !banked && !file_ofs[OFS_W-1]) |-> dmem_addr[ADDR_W-1:OFS_W] == '0);
  a_r4_high_half: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct_sel && !banked && file_ofs[OFS_W-1]) |-> dmem_addr[ADDR_W-1:OFS_W] == '1);
  a_r7_direct: assert property (@(posedge clk) disable iff (!rst_n)
    direct_sel |-> dmem_addr == direct_addr);
  a_r6_old_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_ld && !direct_sel && banked) |=> $past(dmem_addr[ADDR_W-1:OFS_W]) == $past(bank_q));
endmodule

// File: tb/sim_dmem_addr_gen.sv
module sim_dmem_addr_gen;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  file_ofs = '0;
  logic        banked = 0;
  logic        bank_ld = 0;
  logic [7:0]  bank_lit = '0;
  logic        direct_sel = 0;
  logic [11:0] direct_addr = '0;
  logic [11:0] dmem_addr;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  dmem_addr_gen u0 (.*);

  // {ld, lit[8], banked, ofs[8], dsel, daddr[12], expected[12], req[4]}
  localparam int NV = 18;
  localparam logic [46:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b1, 8'h70, 1'b0, 12'h000, 12'h070, 4'd1},  // R1
    {1'b1, 8'h01, 1'b1, 8'h70, 1'b0, 12'h000, 12'h070, 4'd6},  // R6
    {1'b0, 8'h00, 1'b1, 8'h70, 1'b0, 12'h000, 12'h170, 4'd2},  // R2
    {1'b1, 8'hF2, 1'b1, 8'h70, 1'b0, 12'h000, 12'h170, 4'd6},  // R6
    {1'b0, 8'h00, 1'b1, 8'h70, 1'b0, 12'h000, 12'h270, 4'd5},  // R5
    {1'b0, 8'h00, 1'b0, 8'h70, 1'b0, 12'h000, 12'h070, 4'd3},  // R3
    {1'b0, 8'h00, 1'b0, 8'h90, 1'b0, 12'h000, 12'hF90, 4'd4},  // R4
    {1'b0, 8'h00, 1'b0, 8'h80, 1'b0, 12'h000, 12'hF80, 4'd4},  // R4
    {1'b0, 8'h00, 1'b0, 8'h7F, 1'b0, 12'h000, 12'h07F, 4'd3},  // R3
    {1'b0, 8'h00, 1'b0, 8'hFF, 1'b0, 12'h000, 12'hFFF, 4'd4},  // R4
    {1'b0, 8'h00, 1'b1, 8'h55, 1'b1, 12'h1A0, 12'h1A0, 4'd7},  // R7
    {1'b1, 8'h0A, 1'b1, 8'h55, 1'b1, 12'h23F, 12'h23F, 4'd9},  // R9
    {1'b0, 8'h00, 1'b1, 8'h3C, 1'b0, 12'h000, 12'hA3C, 4'd9},  // R9
    {1'b0, 8'h00, 1'b1, 8'hFF, 1'b0, 12'h000, 12'hAFF, 4'd2},  // R2
    {1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 12'h000, 12'hA00, 4'd8},  // R8
    {1'b1, 8'h0F, 1'b0, 8'h81, 1'b0, 12'h000, 12'hF81, 4'd4},  // R4
    {1'b0, 8'h00, 1'b1, 8'h80, 1'b0, 12'h000, 12'hF80, 4'd2},  // R2
    {1'b0, 8'h00, 1'b0, 8'h10, 1'b0, 12'h000, 12'h010, 4'd3}   // R3
  };

  task automatic check(input logic [11:0] exp, input string req);
    checks++;
    if (dmem_addr !== exp) begin
      fails++;
      $display("FAIL %s: dmem_addr=%h expected=%h", req, dmem_addr, exp);
    end
  endtask

  task automatic drive(input logic ld, input logic [7:0] lit, input logic bk,
                       input logic [7:0] ofs, input logic ds, input logic [11:0] da);
    bank_ld = ld; bank_lit = lit; banked = bk;
    file_ofs = ofs; direct_sel = ds; direct_addr = da;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state observed before release
    drive(0, 8'h00, 1, 8'h70, 0, 12'h000);
    #1 check(12'h070, "R1");
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][46], VEC[i][45:38], VEC[i][37], VEC[i][36:29],
            VEC[i][28], VEC[i][27:16]);
      #1 check(VEC[i][15:4], $sformatf("R%0d", VEC[i][3:0]));
    end
    // R8: a shared-window access with no load leaves bank F in place
    @(negedge clk);
    drive(0, 8'h00, 1, 8'h12, 0, 12'h000);
    #1 check(12'hF12, "R8");
    // R1: reset mid-run clears the bank
    @(negedge clk);
    rst_n = 0;
    drive(0, 8'h00, 1, 8'h70, 0, 12'h000);
    #1 check(12'h070, "R1");
    @(negedge clk);
    rst_n = 1;
    // R5: upper literal bits dropped, bank 0 from literal 0xF0
    drive(1, 8'hF0, 1, 8'h01, 0, 12'h000);
    @(negedge clk);
    drive(0, 8'h00, 1, 8'h01, 0, 12'h000);
    #1 check(12'h001, "R5");
    // R7: direct mode with shared window requested still passes direct
    drive(0, 8'h00, 0, 8'hFF, 1, 12'h5A5);
    #1 check(12'h5A5, "R7");
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule